// File: doc/BRIEF.md
# Network-Termination Line Activation Sequencer

This block sequences bring-up and tear-down of a network-termination transceiver. It joins three views of the link. The line side is the two-wire U interface. The subscriber side is the four-wire S/T interface. The third view is a 4-bit command/indicate (C/I) channel on the serial control bus. The block does not look at line samples itself. It consumes condition strobes that other logic has already decoded:

- first line signal element seen
- all-zero B/D content
- line receive level lost
- framing lost on either side
- the activation-timer expiry
- the far-end "user side open" flag
- the loop-back mode
- the C/I code received from the control bus

It produces four outputs: the signal element to transmit on the line, the activation bit sent toward the line side, the C/I code to issue, and an enable for control-bus timing.

Every state decision is taken on a frame strobe, once per frame. A received C/I code counts only after the same value has been seen on two consecutive frames. Failures are handled in the open. An S/T-side failure clears the activation bit toward the far end. A U-side failure (line framing loss or timer expiry) mutes the transmitter and waits for the far end to drop its level before the receiver is reset. In auto-activation mode that waiting state is skipped.

Top module: `nt_act_ctrl`

## Requirements
- R1: Synchronous active-high reset gives `tx_elem`=0 (silence), `act_bit`=0, `ci_tx`=CI_TX_DC (4'b1111) and `tim_en`=0. This is the deactivated state.
- R2: A received C/I code is accepted only when it matches on two consecutive frame strobes. A decision that uses it takes effect at the following frame strobe.
- R3: The control-bus awake state (entered from deactivated on accepted CI_RX_PU=4'b0111) drives `tim_en`=1 and `ci_tx`=CI_TX_PU (4'b0111). Accepted CI_RX_DI (4'b1111) returns it to deactivated.
- R4: From awake, `sl1_det` starts training, which sends `tx_elem`=1 and `ci_tx`=CI_TX_RSY (4'b0100). Training ends only after WIN_MS (default 8) `ms_tick` pulses with `bd_zero` held high. A frame strobe with `bd_zero` low restarts the count. The next state sends `tx_elem`=3 and `ci_tx`=CI_TX_AR (4'b1000).
- R5: In full activation (`uoa`=1 reached, `act_bit`=1, `ci_tx`=CI_TX_AI=4'b1100), `lof_st` moves to the S/T error state with `act_bit`=0.
- R6: In the S/T error state `ci_tx` is CI_TX_ARL (4'b1010) when `loop_mode`=2'd2. For `loop_mode` 0 (normal), 1 (single-channel loop) or 3 it is CI_TX_AR.
- R7: In full activation, `uoa`=0 moves to pending S/T deactivation. That state issues CI_TX_DR (4'b0000) and keeps `act_bit` at its previous value.
- R8: Pending S/T deactivation moves on accepted CI_RX_DI to pending U deactivation (`tx_elem`=0, CI_TX_DR). That state waits for `lsu_det` and then enters receiver reset (`tx_elem`=0, CI_TX_DC, `tim_en`=1). Accepted CI_RX_DI then leads back to deactivated.
- R9: `lof_u` or `t1_exp` in any training or active state (auto mode off) enters pending receive reset: `tx_elem`=0, CI_TX_RSY, `act_bit`=0. The block stays there until `lsu_det`, then enters receiver reset.
- R10: With `auto_act`=1, the U-side failure of R9 goes straight to receiver reset. Pending receive reset is never entered.
- R11: Outputs change only on a frame strobe. A U-side failure outranks a simultaneous S/T failure, and `t1_exp` and `lof_u` in the same frame give one transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle pulse per frame; decision point |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| bd_zero | input | 1 | B and D channel content is all zero |
| sl1_det | input | 1 | First line signal element detected |
| lsu_det | input | 1 | Line receive level lost |
| lof_u | input | 1 | Line-side framing lost |
| lof_st | input | 1 | Subscriber-side framing or signal lost |
| t1_exp | input | 1 | Activation timer expired |
| uoa | input | 1 | Far-end user-side-open flag |
| auto_act | input | 1 | Auto-activation mode |
| loop_mode | input | 2 | 0 normal, 1 single-channel loop, 2 loop-back 2 |
| ci_rx | input | 4 | C/I code received on control bus |
| tx_elem | output | 2 | Signal element to transmit (0 silence, 1 training, 3 framed) |
| act_bit | output | 1 | Activation bit toward line side |
| ci_tx | output | 4 | C/I code issued |
| tim_en | output | 1 | Control-bus timing enable |

## Verification
Two things can arrive in the same frame. One is the line-side failure (timer expiry together with line framing loss). The other is the subscriber-side framing loss. The bench raises `lof_st`, `lof_u` and `t1_exp` at once in full activation. It then expects exactly one step, into pending receive reset with silence and CI_TX_RSY, rather than the S/T error codes. A second frame without level loss must leave the block in that same state. The same collision in auto-activation mode must land in receiver reset.

// File: rtl/nt_act_pkg.sv
package nt_act_pkg;

    localparam int CI_W = 4;

    typedef enum logic [3:0] {
        ST_DEACT,
        ST_AWAKE,
        ST_EQ_TRAIN,
        ST_LINE_SYNC,
        ST_FULL_ACT,
        ST_ST_ERR,
        ST_PEND_ST_DEACT,
        ST_PEND_U_DEACT,
        ST_PEND_RX_RST,
        ST_RX_RST
    } act_state_e;

    typedef enum logic [1:0] {
        TX_SN0 = 2'd0,
        TX_SN1 = 2'd1,
        TX_SN2 = 2'd2,
        TX_SN3 = 2'd3
    } tx_elem_e;

    localparam logic [1:0] LOOP_LB2 = 2'd2;

    typedef struct packed {
        act_state_e      state;
        tx_elem_e        tx;
        logic            act;
        logic [CI_W-1:0] ci;
        logic            tim;
    } fsm_regs_t;

endpackage

// File: rtl/nt_ci_debounce.sv
module nt_ci_debounce #(
    parameter int          W         = 4,
    parameter logic [W-1:0] CODE_NONE = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         frame_stb,
    input  logic [W-1:0] code_in,
    output logic [W-1:0] code_acc
);
    typedef struct packed {
        logic [W-1:0] last;
        logic [W-1:0] acc;
    } deb_t;

    deb_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (frame_stb) begin
            r_d.last = code_in;
            if (code_in == r_q.last) begin
                r_d.acc = code_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{last: CODE_NONE, acc: CODE_NONE};
        end else begin
            r_q <= r_d;
        end
    end

    assign code_acc = r_q.acc;
endmodule

// File: rtl/nt_zero_window.sv
module nt_zero_window #(
    parameter int WIN_MS = 8,
    localparam int CNT_W = $clog2(WIN_MS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic frame_stb,
    input  logic bd_zero,
    input  logic ms_tick,
    output logic win_ok
);
    localparam logic [CNT_W-1:0] WIN_C = CNT_W'(WIN_MS);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!enable) begin
            cnt_d = '0;
        end else if (frame_stb && !bd_zero) begin
            cnt_d = '0;
        end else if (ms_tick && (cnt_q < WIN_C)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign win_ok = (cnt_q >= WIN_C);
endmodule

// File: rtl/nt_act_fsm.sv
module nt_act_fsm
    import nt_act_pkg::*;
#(
    parameter logic [CI_W-1:0] CI_RX_PU  = 4'b0111,
    parameter logic [CI_W-1:0] CI_RX_DI  = 4'b1111,
    parameter logic [CI_W-1:0] CI_TX_DC  = 4'b1111,
    parameter logic [CI_W-1:0] CI_TX_PU  = 4'b0111,
    parameter logic [CI_W-1:0] CI_TX_RSY = 4'b0100,
    parameter logic [CI_W-1:0] CI_TX_AR  = 4'b1000,
    parameter logic [CI_W-1:0] CI_TX_ARL = 4'b1010,
    parameter logic [CI_W-1:0] CI_TX_AI  = 4'b1100,
    parameter logic [CI_W-1:0] CI_TX_DR  = 4'b0000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            frame_stb,
    input  logic            win_ok,
    input  logic            sl1_det,
    input  logic            lsu_det,
    input  logic            lof_u,
    input  logic            lof_st,
    input  logic            t1_exp,
    input  logic            uoa,
    input  logic            auto_act,
    input  logic [1:0]      loop_mode,
    input  logic [CI_W-1:0] ci_acc,
    output logic            in_train,
    output fsm_regs_t       regs
);
    fsm_regs_t  r_d, r_q;
    act_state_e nxt;
    logic       u_fail;
    logic       line_up;

    always_comb begin
        u_fail  = lof_u || t1_exp;
        line_up = (r_q.state inside {ST_EQ_TRAIN, ST_LINE_SYNC, ST_FULL_ACT,
                                     ST_ST_ERR, ST_PEND_ST_DEACT});
        nxt = r_q.state;
        if (line_up && u_fail) begin
            nxt = auto_act ? ST_RX_RST : ST_PEND_RX_RST;
        end else begin
            unique case (r_q.state)
                ST_DEACT:         if (ci_acc == CI_RX_PU) nxt = ST_AWAKE;
                ST_AWAKE: begin
                    if (ci_acc == CI_RX_DI) nxt = ST_DEACT;
                    else if (sl1_det)       nxt = ST_EQ_TRAIN;
                end
                ST_EQ_TRAIN:      if (win_ok) nxt = ST_LINE_SYNC;
                ST_LINE_SYNC:     if (uoa) nxt = ST_FULL_ACT;
                ST_FULL_ACT: begin
                    if (lof_st)    nxt = ST_ST_ERR;
                    else if (!uoa) nxt = ST_PEND_ST_DEACT;
                end
                ST_ST_ERR:        if (!lof_st) nxt = ST_LINE_SYNC;
                ST_PEND_ST_DEACT: if (ci_acc == CI_RX_DI) nxt = ST_PEND_U_DEACT;
                ST_PEND_U_DEACT:  if (lsu_det) nxt = ST_RX_RST;
                ST_PEND_RX_RST:   if (lsu_det) nxt = ST_RX_RST;
                ST_RX_RST:        if (ci_acc == CI_RX_DI) nxt = ST_DEACT;
                default:          nxt = ST_DEACT;
            endcase
        end

        r_d = r_q;
        if (frame_stb) begin
            r_d.state = nxt;
            r_d.tim   = (nxt != ST_DEACT);
            r_d.act   = 1'b0;
            unique case (nxt)
                ST_DEACT: begin
                    r_d.tx = TX_SN0; r_d.ci = CI_TX_DC;
                end
                ST_AWAKE: begin
                    r_d.tx = TX_SN0; r_d.ci = CI_TX_PU;
                end
                ST_EQ_TRAIN: begin
                    r_d.tx = TX_SN1; r_d.ci = CI_TX_RSY;
                end
                ST_LINE_SYNC: begin
                    r_d.tx = TX_SN3; r_d.ci = CI_TX_AR;
                end
                ST_FULL_ACT: begin
                    r_d.tx = TX_SN3; r_d.ci = CI_TX_AI; r_d.act = 1'b1;
                end
                ST_ST_ERR: begin
                    r_d.tx = TX_SN3;
                    r_d.ci = (loop_mode == LOOP_LB2) ? CI_TX_ARL : CI_TX_AR;
                end
                ST_PEND_ST_DEACT: begin
                    r_d.tx = TX_SN3; r_d.ci = CI_TX_DR; r_d.act = r_q.act;
                end
                ST_PEND_U_DEACT: begin
                    r_d.tx = TX_SN0; r_d.ci = CI_TX_DR;
                end
                ST_PEND_RX_RST: begin
                    r_d.tx = TX_SN0; r_d.ci = CI_TX_RSY;
                end
                ST_RX_RST: begin
                    r_d.tx = TX_SN0; r_d.ci = CI_TX_DC;
                end
                default: begin
                    r_d.tx = TX_SN0; r_d.ci = CI_TX_DC;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{state: ST_DEACT, tx: TX_SN0, act: 1'b0, ci: CI_TX_DC, tim: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign regs     = r_q;
    assign in_train = (r_q.state == ST_EQ_TRAIN);
endmodule

// File: rtl/nt_act_ctrl.sv
module nt_act_ctrl
    import nt_act_pkg::*;
#(
    parameter int              WIN_MS    = 8,
    parameter logic [CI_W-1:0] CI_NONE   = 4'b1110,
    parameter logic [CI_W-1:0] CI_RX_PU  = 4'b0111,
    parameter logic [CI_W-1:0] CI_RX_DI  = 4'b1111,
    parameter logic [CI_W-1:0] CI_TX_DC  = 4'b1111,
    parameter logic [CI_W-1:0] CI_TX_PU  = 4'b0111,
    parameter logic [CI_W-1:0] CI_TX_RSY = 4'b0100,
    parameter logic [CI_W-1:0] CI_TX_AR  = 4'b1000,
    parameter logic [CI_W-1:0] CI_TX_ARL = 4'b1010,
    parameter logic [CI_W-1:0] CI_TX_AI  = 4'b1100,
    parameter logic [CI_W-1:0] CI_TX_DR  = 4'b0000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_stb,
    input  logic       ms_tick,
    input  logic       bd_zero,
    input  logic       sl1_det,
    input  logic       lsu_det,
    input  logic       lof_u,
    input  logic       lof_st,
    input  logic       t1_exp,
    input  logic       uoa,
    input  logic       auto_act,
    input  logic [1:0] loop_mode,
    input  logic [3:0] ci_rx,
    output logic [1:0] tx_elem,
    output logic       act_bit,
    output logic [3:0] ci_tx,
    output logic       tim_en
);
    logic [CI_W-1:0] ci_acc;
    logic            win_ok;
    logic            in_train;
    fsm_regs_t       regs;

    nt_ci_debounce #(.W(CI_W), .CODE_NONE(CI_NONE)) u_deb (
        .clk(clk), .rst(rst), .frame_stb(frame_stb),
        .code_in(ci_rx), .code_acc(ci_acc)
    );

    nt_zero_window #(.WIN_MS(WIN_MS)) u_zwin (
        .clk(clk), .rst(rst), .enable(in_train), .frame_stb(frame_stb),
        .bd_zero(bd_zero), .ms_tick(ms_tick), .win_ok(win_ok)
    );

    nt_act_fsm #(
        .CI_RX_PU(CI_RX_PU), .CI_RX_DI(CI_RX_DI), .CI_TX_DC(CI_TX_DC),
        .CI_TX_PU(CI_TX_PU), .CI_TX_RSY(CI_TX_RSY), .CI_TX_AR(CI_TX_AR),
        .CI_TX_ARL(CI_TX_ARL), .CI_TX_AI(CI_TX_AI), .CI_TX_DR(CI_TX_DR)
    ) u_fsm (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .win_ok(win_ok),
        .sl1_det(sl1_det), .lsu_det(lsu_det), .lof_u(lof_u), .lof_st(lof_st),
        .t1_exp(t1_exp), .uoa(uoa), .auto_act(auto_act), .loop_mode(loop_mode),
        .ci_acc(ci_acc), .in_train(in_train), .regs(regs)
    );

    assign tx_elem = regs.tx;
    assign act_bit = regs.act;
    assign ci_tx   = regs.ci;
    assign tim_en  = regs.tim;
endmodule

// File: rtl/nt_act_chk.sv
module nt_act_chk #(
    parameter logic [3:0] CI_TX_DC  = 4'b1111,
    parameter logic [3:0] CI_TX_RSY = 4'b0100,
    parameter logic [3:0] CI_TX_AI  = 4'b1100,
    parameter logic [3:0] CI_TX_DR  = 4'b0000
) (
    input logic       clk,
    input logic       rst,
    input logic       frame_stb,
    input logic       lsu_det,
    input logic       lof_u,
    input logic       lof_st,
    input logic       t1_exp,
    input logic       uoa,
    input logic       auto_act,
    input logic [1:0] tx_elem,
    input logic       act_bit,
    input logic [3:0] ci_tx,
    input logic       tim_en
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (tx_elem == 2'd0 && !act_bit && ci_tx == CI_TX_DC && !tim_en));

    // R11
    frame_only_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> ($stable(tx_elem) && $stable(act_bit) && $stable(ci_tx) && $stable(tim_en)));

    // R5
    st_loss_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && act_bit && ci_tx == CI_TX_AI && lof_st && !lof_u && !t1_exp) |=> !act_bit);

    // R7
    act_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && act_bit && ci_tx == CI_TX_AI && !uoa && !lof_st && !lof_u && !t1_exp)
        |=> (act_bit && ci_tx == CI_TX_DR));

    // R9
    rx_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_elem == 2'd0 && ci_tx == CI_TX_RSY && !lsu_det) |=> (tx_elem == 2'd0 && ci_tx == CI_TX_RSY));

    // R10
    auto_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (auto_act && frame_stb && (lof_u || t1_exp) && tx_elem == 2'd3)
        |=> (tx_elem == 2'd0 && ci_tx == CI_TX_DC && tim_en));
endmodule

bind nt_act_ctrl nt_act_chk #(
    .CI_TX_DC(CI_TX_DC), .CI_TX_RSY(CI_TX_RSY), .CI_TX_AI(CI_TX_AI), .CI_TX_DR(CI_TX_DR)
) u_chk (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .lsu_det(lsu_det), .lof_u(lof_u),
    .lof_st(lof_st), .t1_exp(t1_exp), .uoa(uoa), .auto_act(auto_act),
    .tx_elem(tx_elem), .act_bit(act_bit), .ci_tx(ci_tx), .tim_en(tim_en)
);

// File: tb/nt_act_ctrl_test.sv
module nt_act_ctrl_test;
    localparam int WIN = 8;
    localparam logic [3:0] RX_PU = 4'b0111, RX_DI = 4'b1111;
    localparam logic [3:0] DC = 4'b1111, PU = 4'b0111, RSY = 4'b0100, AR = 4'b1000,
                           ARL = 4'b1010, AI = 4'b1100, DR = 4'b0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_stb = 0, ms_tick = 0, bd_zero = 0, sl1_det = 0, lsu_det = 0;
    logic lof_u = 0, lof_st = 0, t1_exp = 0, uoa = 0, auto_act = 0;
    logic [1:0] loop_mode = 2'd0;
    logic [3:0] ci_rx = 4'b1110;
    logic [1:0] tx_elem;
    logic       act_bit;
    logic [3:0] ci_tx;
    logic       tim_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    nt_act_ctrl #(.WIN_MS(WIN)) uut (
        .clk(clk), .rst(rst), .frame_stb(frame_stb), .ms_tick(ms_tick), .bd_zero(bd_zero),
        .sl1_det(sl1_det), .lsu_det(lsu_det), .lof_u(lof_u), .lof_st(lof_st),
        .t1_exp(t1_exp), .uoa(uoa), .auto_act(auto_act), .loop_mode(loop_mode),
        .ci_rx(ci_rx), .tx_elem(tx_elem), .act_bit(act_bit), .ci_tx(ci_tx), .tim_en(tim_en)
    );

    task automatic expect_out(string req, logic [1:0] tx, logic act, logic [3:0] ci, logic tim);
        logic [7:0] got, exp;
        got = {tx_elem, act_bit, ci_tx, tim_en};
        exp = {tx, act, ci, tim};
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got tx=%0d act=%0d ci=%b tim=%0d expected tx=%0d act=%0d ci=%b tim=%0d",
                     req, got[7:6], got[5], got[4:1], got[0], tx, act, ci, tim);
        end
    endtask

    task automatic frame();
        @(negedge clk) frame_stb = 1'b1;
        @(negedge clk) frame_stb = 1'b0;
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ms_tick = 1'b1;
            @(negedge clk) ms_tick = 1'b0;
        end
    endtask

    task automatic bring_up();
        ci_rx = RX_PU;
        frame(); frame(); frame();
        sl1_det = 1'b1; frame(); sl1_det = 1'b0;
        bd_zero = 1'b1; tick(WIN); frame();
        uoa = 1'b1; frame();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        expect_out("R1", 2'd0, 1'b0, DC, 1'b0);

        // R2 single match is not enough
        ci_rx = RX_PU;
        frame(); expect_out("R2", 2'd0, 0, DC, 0);
        frame(); expect_out("R2", 2'd0, 0, DC, 0);
        frame(); expect_out("R3", 2'd0, 0, PU, 1);

        // R4 training with interrupted window
        sl1_det = 1'b1; frame(); sl1_det = 1'b0;
        expect_out("R4", 2'd1, 0, RSY, 1);
        bd_zero = 1'b1; tick(5);
        bd_zero = 1'b0; frame(); expect_out("R4", 2'd1, 0, RSY, 1);
        bd_zero = 1'b1; tick(WIN - 1); frame(); expect_out("R4", 2'd1, 0, RSY, 1);
        tick(1); frame(); expect_out("R4", 2'd3, 0, AR, 1);

        uoa = 1'b1; frame(); expect_out("R5", 2'd3, 1, AI, 1);

        // R6 sweep every loop mode
        for (int m = 0; m < 4; m++) begin
            loop_mode = 2'(m);
            lof_st = 1'b1; frame();
            expect_out((m == 2) ? "R6 lb2" : "R6 ar", 2'd3, 0, (m == 2) ? ARL : AR, 1);
            lof_st = 1'b0; frame(); expect_out("R5", 2'd3, 0, AR, 1);
            frame(); expect_out("R5", 2'd3, 1, AI, 1);
        end
        loop_mode = 2'd0;

        // R11 nothing moves without a frame strobe
        lof_st = 1'b1; lof_u = 1'b1;
        repeat (10) @(negedge clk);
        expect_out("R11", 2'd3, 1, AI, 1);
        t1_exp = 1'b1; frame();
        expect_out("R11", 2'd0, 0, RSY, 1);
        lof_st = 1'b0; lof_u = 1'b0; t1_exp = 1'b0;
        frame(); expect_out("R9", 2'd0, 0, RSY, 1);
        lsu_det = 1'b1; frame(); lsu_det = 1'b0;
        expect_out("R9", 2'd0, 0, DC, 1);
        ci_rx = RX_DI; frame(); frame(); expect_out("R9", 2'd0, 0, DC, 1);
        frame(); expect_out("R9", 2'd0, 0, DC, 0);

        // R3 awake returns on idle code
        ci_rx = RX_PU; frame(); frame(); frame();
        expect_out("R3", 2'd0, 0, PU, 1);
        ci_rx = RX_DI; frame(); frame(); expect_out("R3", 2'd0, 0, PU, 1);
        frame(); expect_out("R3", 2'd0, 0, DC, 0);

        // R7 / R8 orderly deactivation
        uoa = 1'b0; bring_up();
        expect_out("R7", 2'd3, 1, AI, 1);
        uoa = 1'b0; frame(); expect_out("R7", 2'd3, 1, DR, 1);
        frame(); expect_out("R7", 2'd3, 1, DR, 1);
        ci_rx = RX_DI; frame(); frame(); expect_out("R8", 2'd3, 1, DR, 1);
        frame(); expect_out("R8", 2'd0, 0, DR, 1);
        frame(); expect_out("R8", 2'd0, 0, DR, 1);
        lsu_det = 1'b1; frame(); lsu_det = 1'b0;
        expect_out("R8", 2'd0, 0, DC, 1);
        frame(); expect_out("R8", 2'd0, 0, DC, 0);

        // R10 auto-activation skips pending receive reset
        auto_act = 1'b1; uoa = 1'b0; bring_up();
        expect_out("R10", 2'd3, 1, AI, 1);
        t1_exp = 1'b1; lof_st = 1'b1; frame(); t1_exp = 1'b0; lof_st = 1'b0;
        expect_out("R10", 2'd0, 0, DC, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule